// File: doc/BRIEF.md
# Real-Time Clock Alarm and Periodic Interrupt Controller

This block produces the single interrupt request of a real-time clock. It compares the current calendar time (seconds, minutes, hours, day, month, year), supplied as inputs by the timekeeping counters, with a set of alarm fields that software programs. When all six fields become equal it records an alarm event. A periodic strobe from the timekeeping side is a second event source. Each source has its own enable bit and its own sticky status bit. The output request is the OR of every source whose enable and status bits are both set.

Software reaches the enable, status and alarm registers through a simple write/read port. Every register is write-protected except two key registers. Writing the first key value and then the second key value opens the block. A wrong value written to either key register locks it again. Writes to the enable and status registers are also held off while the time base is running and reports that it is busy updating.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, enable = 0x00, status = 0x00, every alarm field reads 0xFF, the block is locked, and `irq` and `rdata` are 0.
- R2: Writing KEY_A (0xA7) to address 8 and then KEY_B (0x5C) to address 9 unlocks the block from the next cycle on. While the block is locked, writes to addresses 0 to 7 are ignored.
- R3: Writing a value other than KEY_A to address 8, or any value to address 9 when KEY_A has not been accepted first, locks the block. KEY_B written alone does not unlock it.
- R4: While `clk_running`=1 and `busy`=1, writes to the enable register (address 0) and the status register (address 1) are ignored. Alarm field writes (addresses 2 to 7) are not affected by `busy`.
- R5: Field i of `cur_time` occupies bits [8i+7:8i], in the order seconds, minutes, hours, day, month, year. The alarm fields sit at addresses 2 to 7 in the same order. Status bit 0 (alarm) is set on the clock edge where all six fields first become equal. A mismatch in any one field sets nothing.
- R6: An alarm match that stays unchanged does not set status bit 0 again once software has cleared it. A later new match does set it again. Status bits are set whatever the enable bits hold.
- R7: Writing 1 to a status bit clears that bit. Writing 0 leaves it unchanged.
- R8: A cycle with `periodic_tick`=1 sets status bit 1 (periodic), which stays set until it is cleared.
- R9: Enable bit 0 gates the alarm source and enable bit 1 gates the periodic source. `irq` is registered and equals the OR of (enable AND status), one cycle after those registers change.
- R10: A cycle with `rd_en`=1 returns the addressed register on `rdata` with `rvalid`=1 on the next cycle. The enable and status registers read as zero-extended bit vectors, and the key addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_time | input | 48 | Current time, six 8-bit fields, seconds in the low byte |
| periodic_tick | input | 1 | Periodic event strobe |
| clk_running | input | 1 | Time base is counting |
| busy | input | 1 | Time base is updating its fields |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| rvalid | output | 1 | Read data valid |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach from the ports is the one where software has cleared an alarm while the time still equals the alarm fields. Only the edge detection keeps the bit from setting again in that case. The stimulus holds `cur_time` on the matching value across the clear and several idle cycles, then reads status and `irq`. After that it re-arms the alarm in two ways: by rewriting an alarm field while `busy` is high, and then by moving the time onto the new value. Unlocking, relocking with a wrong key and a lone second key are each followed by an enable write and a readback, so that the lock state shows at the read port.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int ADR_ENABLE = 0;
  localparam int ADR_STATUS = 1;
  localparam int ADR_ALARM0 = 2;
  localparam int ADR_KICK0  = 8;
  localparam int ADR_KICK1  = 9;

  localparam int SRC_ALARM    = 0;
  localparam int SRC_PERIODIC = 1;
  localparam int NUM_SRC      = 2;

  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_state_t;
endpackage

// File: rtl/rtc_unlock_fsm.sv
module rtc_unlock_fsm
  import rtc_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [DATA_W-1:0] KEY_A = 8'hA7,
  parameter logic [DATA_W-1:0] KEY_B = 8'h5C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlocked
);
  lock_state_t state_q;

  logic hit_k0, hit_k1;
  assign hit_k0 = wr_en && (addr == ADDR_W'(ADR_KICK0));
  assign hit_k1 = wr_en && (addr == ADDR_W'(ADR_KICK1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LK_CLOSED;
    end else if (hit_k0) begin
      state_q <= (wdata == KEY_A) ? LK_HALF : LK_CLOSED;
    end else if (hit_k1) begin
      state_q <= (wdata == KEY_B && state_q != LK_CLOSED) ? LK_OPEN : LK_CLOSED;
    end
  end

  assign unlocked = (state_q == LK_OPEN);

  // R2: opening only follows the second key
  p_open_needs_key_b_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(hit_k1 && wdata == KEY_B));

  // R3: a wrong first key closes the block
  p_bad_key_relocks_r3: assert property (@(posedge clk) disable iff (rst)
    (hit_k0 && wdata != KEY_A) |=> !unlocked);

  // R3: second key from the closed state never opens
  p_lone_key_b_r3: assert property (@(posedge clk) disable iff (rst)
    (hit_k1 && state_q == LK_CLOSED) |=> !unlocked);
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int DATA_W     = 8,
  parameter int NUM_FIELDS = 6,
  localparam int TIME_W    = DATA_W * NUM_FIELDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] cur_time,
  input  logic [TIME_W-1:0] alarm_time,
  output logic              hit
);
  logic [NUM_FIELDS-1:0] field_eq;
  logic match, match_q;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    assign field_eq[i] = (cur_time[i*DATA_W +: DATA_W] == alarm_time[i*DATA_W +: DATA_W]);
  end

  assign match = &field_eq;

  // Held high through reset so that a match present at reset release is not an event
  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b1;
    else     match_q <= match;
  end

  assign hit = match && !match_q;

  // R6: an event is a single-cycle pulse
  p_hit_single_r6: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
endmodule

// File: rtl/rtc_irq_regs.sv
module rtc_irq_regs
  import rtc_irq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 4,
  parameter int NUM_FIELDS = 6,
  localparam int TIME_W    = DATA_W * NUM_FIELDS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               unlocked,
  input  logic               clk_running,
  input  logic               busy,
  input  logic               alarm_hit,
  input  logic               periodic_tick,
  output logic [TIME_W-1:0]  alarm_time,
  output logic [NUM_SRC-1:0] enable,
  output logic [NUM_SRC-1:0] status,
  output logic [DATA_W-1:0]  rdata,
  output logic               rvalid
);
  logic wr_ok, ctrl_ok;
  logic [NUM_SRC-1:0] set_vec, clr_vec;
  logic [DATA_W-1:0] alarm_q [NUM_FIELDS];
  logic [DATA_W-1:0] rd_mux;

  assign wr_ok   = wr_en && unlocked;
  assign ctrl_ok = wr_ok && (!clk_running || !busy);

  // Enable register
  always_ff @(posedge clk) begin
    if (rst) enable <= '0;
    else if (ctrl_ok && addr == ADDR_W'(ADR_ENABLE)) enable <= wdata[NUM_SRC-1:0];
  end

  // Sticky status, set has priority over clear
  always_comb begin
    set_vec = '0;
    set_vec[SRC_ALARM]    = alarm_hit;
    set_vec[SRC_PERIODIC] = periodic_tick;
    clr_vec = (ctrl_ok && addr == ADDR_W'(ADR_STATUS)) ? wdata[NUM_SRC-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~clr_vec) | set_vec;
  end

  // Alarm fields, protected only by the lock
  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_alarm
    always_ff @(posedge clk) begin
      if (rst) alarm_q[i] <= '1;
      else if (wr_ok && addr == ADDR_W'(ADR_ALARM0 + i)) alarm_q[i] <= wdata;
    end
    assign alarm_time[i*DATA_W +: DATA_W] = alarm_q[i];
  end

  // Read path
  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(ADR_ENABLE)) rd_mux[NUM_SRC-1:0] = enable;
    if (addr == ADDR_W'(ADR_STATUS)) rd_mux[NUM_SRC-1:0] = status;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (addr == ADDR_W'(ADR_ALARM0 + i)) rd_mux = alarm_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end

  // R2: locked writes leave the enable register alone
  p_locked_enable_r2: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && wr_en && addr == ADDR_W'(ADR_ENABLE)) |=> $stable(enable));

  // R4: busy time base blocks enable writes
  p_busy_enable_r4: assert property (@(posedge clk) disable iff (rst)
    (clk_running && busy && wr_en && addr == ADDR_W'(ADR_ENABLE)) |=> $stable(enable));

  // R5: alarm status only rises on a comparator event
  p_alarm_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(status[SRC_ALARM]) |-> $past(alarm_hit));

  // R7: alarm status stays unless a permitted write of 1 clears it
  p_sticky_alarm_r7: assert property (@(posedge clk) disable iff (rst)
    (status[SRC_ALARM] && !(ctrl_ok && addr == ADDR_W'(ADR_STATUS) && wdata[SRC_ALARM]))
      |=> status[SRC_ALARM]);

  // R8: periodic strobe always leaves its status bit set
  p_tick_sets_r8: assert property (@(posedge clk) disable iff (rst)
    periodic_tick |=> status[SRC_PERIODIC]);

  // R10: read data valid follows a read by one cycle
  p_read_valid_r10: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid);
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_irq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 4,
  parameter int NUM_FIELDS = 6,
  parameter logic [DATA_W-1:0] KEY_A = 8'hA7,
  parameter logic [DATA_W-1:0] KEY_B = 8'h5C,
  localparam int TIME_W    = DATA_W * NUM_FIELDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] cur_time,
  input  logic              periodic_tick,
  input  logic              clk_running,
  input  logic              busy,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              irq
);
  logic               unlocked;
  logic               alarm_hit;
  logic [TIME_W-1:0]  alarm_time;
  logic [NUM_SRC-1:0] enable, status;

  rtc_unlock_fsm #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) u_lock (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .unlocked(unlocked)
  );

  rtc_alarm_cmp #(
    .DATA_W(DATA_W), .NUM_FIELDS(NUM_FIELDS)
  ) u_cmp (
    .clk(clk), .rst(rst), .cur_time(cur_time), .alarm_time(alarm_time),
    .hit(alarm_hit)
  );

  rtc_irq_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_FIELDS(NUM_FIELDS)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .unlocked(unlocked), .clk_running(clk_running),
    .busy(busy), .alarm_hit(alarm_hit), .periodic_tick(periodic_tick),
    .alarm_time(alarm_time), .enable(enable), .status(status),
    .rdata(rdata), .rvalid(rvalid)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(enable & status);
  end

  // R9: no enabled pending source means no request
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    ((enable & status) == '0) |=> !irq);

  // R9: an enabled pending source raises the request
  p_irq_raise_r9: assert property (@(posedge clk) disable iff (rst)
    ((enable & status) != '0) |=> irq);
endmodule

// File: tb/rtc_alarm_irq_test.sv
module rtc_alarm_irq_test;
  localparam logic [3:0] A_EN = 4'd0, A_ST = 4'd1, A_AL0 = 4'd2, A_K0 = 4'd8, A_K1 = 4'd9;
  localparam logic [7:0] KA = 8'hA7, KB = 8'h5C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [47:0] cur_time = '0;
  logic periodic_tick = 1'b0, clk_running = 1'b0, busy = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rvalid, irq;

  int checks = 0;
  int fails = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  rtc_alarm_irq uut (
    .clk(clk), .rst(rst), .cur_time(cur_time), .periodic_tick(periodic_tick),
    .clk_running(clk_running), .busy(busy), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .irq(irq)
  );

  task automatic note(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_expect(input logic [3:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    note(irq == e, tag, {7'd0, irq}, {7'd0, e});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      if (exp_q.size() == 0) begin
        note(1'b0, "R10 unexpected read data", rdata, 8'h00);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        note(rdata == e, t, rdata, e);
      end
    end
  end

  function automatic logic [47:0] mk(input logic [7:0] s, mi, h, d, mo, y);
    return {y, mo, d, h, mi, s};
  endfunction

  bit done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      note(1'b0, "watchdog expired", 8'h00, 8'h01);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    note(rdata == 8'h00, "R1 rdata after reset", rdata, 8'h00);
    rd_expect(A_EN, 8'h00, "R1 enable reset");
    rd_expect(A_ST, 8'h00, "R1 status reset");
    rd_expect(A_AL0 + 4'd5, 8'hFF, "R1 alarm year reset");

    // R2 locked writes ignored
    wr(A_EN, 8'h03);
    rd_expect(A_EN, 8'h00, "R2 locked enable write ignored");
    wr(A_AL0, 8'h11);
    rd_expect(A_AL0, 8'hFF, "R2 locked alarm write ignored");
    // R3 second key alone does not unlock
    wr(A_K1, KB);
    wr(A_EN, 8'h03);
    rd_expect(A_EN, 8'h00, "R3 lone second key keeps lock");
    // R2 proper unlock
    wr(A_K0, KA);
    wr(A_K1, KB);
    wr(A_EN, 8'h00);
    rd_expect(A_K0, 8'h00, "R10 key address reads zero");

    // R5 program alarm: 09:15:30 day 12 month 06 year 24
    wr(A_AL0 + 4'd0, 8'h30);
    wr(A_AL0 + 4'd1, 8'h15);
    wr(A_AL0 + 4'd2, 8'h09);
    wr(A_AL0 + 4'd3, 8'h12);
    wr(A_AL0 + 4'd4, 8'h06);
    wr(A_AL0 + 4'd5, 8'h24);
    rd_expect(A_AL0 + 4'd2, 8'h09, "R10 alarm hours readback");
    // R5 year differs only
    @(negedge clk); cur_time = mk(8'h30, 8'h15, 8'h09, 8'h12, 8'h06, 8'h23);
    idle(2);
    rd_expect(A_ST, 8'h00, "R5 single field mismatch no alarm");
    // R5 full match
    @(negedge clk); cur_time = mk(8'h30, 8'h15, 8'h09, 8'h12, 8'h06, 8'h24);
    idle(2);
    rd_expect(A_ST, 8'h01, "R5 full match sets alarm status");
    chk_irq(1'b0, "R6 status set while disabled, irq low");
    // R9 enable alarm
    wr(A_EN, 8'h01);
    idle(1);
    chk_irq(1'b1, "R9 enabled alarm raises irq");
    // R7 write 0 keeps
    wr(A_ST, 8'h00);
    rd_expect(A_ST, 8'h01, "R7 write of 0 keeps status");
    // R7 write 1 clears, R6 held match does not re-set
    wr(A_ST, 8'h01);
    idle(1);
    chk_irq(1'b0, "R9 irq drops after clear");
    idle(4);
    rd_expect(A_ST, 8'h00, "R6 held match does not re-set");

    // R8 periodic tick, source disabled
    @(negedge clk); periodic_tick = 1'b1;
    @(negedge clk); periodic_tick = 1'b0;
    idle(1);
    chk_irq(1'b0, "R9 periodic pending but disabled");
    idle(3);
    rd_expect(A_ST, 8'h02, "R8 periodic status sticky");
    wr(A_EN, 8'h03);
    idle(1);
    chk_irq(1'b1, "R9 periodic enabled raises irq");

    // R4 busy gating
    @(negedge clk); clk_running = 1'b1; busy = 1'b1;
    wr(A_ST, 8'h02);
    rd_expect(A_ST, 8'h02, "R4 status clear blocked while busy");
    wr(A_EN, 8'h00);
    rd_expect(A_EN, 8'h03, "R4 enable write blocked while busy");
    wr(A_AL0, 8'h31);
    rd_expect(A_AL0, 8'h31, "R4 alarm write passes while busy");
    chk_irq(1'b1, "R4 irq unchanged while busy");
    @(negedge clk); busy = 1'b0;
    wr(A_ST, 8'h02);
    idle(1);
    chk_irq(1'b0, "R7 periodic clear drops irq");
    rd_expect(A_ST, 8'h00, "R4 status clear allowed when not busy");

    // R6 new match re-arms
    @(negedge clk); cur_time = mk(8'h31, 8'h15, 8'h09, 8'h12, 8'h06, 8'h24);
    idle(2);
    rd_expect(A_ST, 8'h01, "R6 new match sets status again");
    chk_irq(1'b1, "R9 re-armed alarm raises irq");

    // R3 wrong first key relocks
    wr(A_K0, 8'h00);
    wr(A_EN, 8'h00);
    rd_expect(A_EN, 8'h03, "R3 wrong key relocks");
    wr(A_K0, KA);
    wr(A_K1, 8'h77);
    wr(A_EN, 8'h00);
    rd_expect(A_EN, 8'h03, "R3 wrong second key relocks");
    wr(A_K0, KA);
    wr(A_K1, KB);
    wr(A_EN, 8'h00);
    rd_expect(A_EN, 8'h00, "R2 unlock again works");
    idle(1);
    chk_irq(1'b0, "R9 all disabled irq low");

    idle(3);
    if (exp_q.size() != 0) note(1'b0, "R10 reads left unanswered", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule